// File: doc/BRIEF.md
# Self-Routing Omega Switching Network

This block moves up to P packets per clock from P source ports to P destination ports through a multistage fabric of 2×2 switching cells. P is a power of two and the fabric has log2(P) stages. Ahead of every stage the lines are permuted by a perfect shuffle, so line i feeds line j, where j is i rotated left by one bit across log2(P) bits. Each stage holds P/2 cells, so the fabric has (P/2)·log2(P) cells in all. There is no central controller. Every packet carries its source number (the index of the port it entered on) and its destination number through the fabric. At each stage, the cell it meets compares one source bit with the matching destination bit and sets its mode from that comparison.

A cell works in one of two modes. In pass-through, the upper input goes to the upper output and the lower to the lower. In crossover, they swap. At stage k (counted from 1) the bit examined is bit log2(P)−k, so the most significant bit is examined first. Equal bits select pass-through and unequal bits select crossover. The fabric is blocking: two packets with distinct sources and distinct destinations can still ask for the same cell output. When that happens, the packet on the upper line wins. The other packet is discarded for that cycle and a blocked flag is raised on its source index.

The fabric is combinational and the outputs are registered. Each destination port presents a valid flag, the payload and the source index one clock after the inputs are sampled. The streams carry only a valid flag. There is no ready signal and no back-pressure in either direction. An input is taken on every clock edge at which its valid is high. An output word is shown for exactly one cycle and the next edge replaces it. A source that sees its blocked flag must resend the packet itself if it still needs to go.

Top module: `omega_net`

## Requirements
- R1: While reset is asserted and after its release, before any valid input is sampled, every `dst_valid` bit and every `src_blocked` bit is 0.
- R2: A packet sampled on source s with destination d appears on destination port d exactly one clock later, with `dst_valid[d]`=1, `dst_data[d]` equal to its payload and `dst_src[d]`=s.
- R3: At stage k the cell uses pass-through when bit log2(P)−k of the source equals that bit of the destination, and crossover otherwise. For P=8, a packet from source 1 to destination 4 therefore arrives on output 4.
- R4: A full permutation that causes no conflict, such as the identity or the bitwise complement d = s XOR (P−1), delivers all P packets in the same cycle with no blocked flag.
- R5: When two packets in one cell ask for the same output, the packet on the upper (even) line of that cell is the one forwarded.
- R6: The losing packet does not appear on any output. `src_blocked` is set at the loser's source index one clock after the inputs are sampled, and only for that one cycle.
- R7: An input whose valid bit is 0 has no effect: its destination and payload are ignored and it produces no output and no blocked flag.
- R8: Every valid packet either is delivered exactly once or is reported blocked, never both. The number of valid outputs plus the number of blocked flags equals the number of valid inputs sampled one clock earlier.
- R9: A conflict that first appears at a later stage, after the two packets have left different cells of stage 1, is resolved and reported in the same way as a conflict at stage 1.
- R10: Outputs hold no state beyond one cycle. An idle input cycle clears every `dst_valid` bit, and back-to-back packets each appear in their own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | P | Per-source packet present |
| src_dest | input | P×log2(P) | Per-source destination number |
| src_data | input | P×W | Per-source payload |
| dst_valid | output | P | Per-destination packet present, registered |
| dst_data | output | P×W | Per-destination payload, registered |
| dst_src | output | P×log2(P) | Source number of the delivered packet, registered |
| src_blocked | output | P | Per-source flag for a packet lost to a conflict, registered |

## Verification
All results, both deliveries and blocked flags, are due exactly one clock after the cycle in which the inputs are sampled, because the only registers are at the outputs. Each scenario task drives its inputs on a falling edge, waits for the next rising edge and samples one nanosecond later. At that point it compares the whole `dst_valid` and `src_blocked` vectors, together with the source and payload of every port that should be occupied, against values worked out by hand from the routing rule. Tests that chain cycles, for example back-to-back packets, an idle cycle after a conflict, or idle inputs, check each cycle at its own sampling point. This shows that no result arrives early, late or held over.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Perfect shuffle: rotate a lg-bit line index left by one position.
  function automatic int unsigned shuffle_idx(int unsigned i, int unsigned lg);
    int unsigned mask;
    mask = (1 << lg) - 1;
    return ((i << 1) | (i >> (lg - 1))) & mask;
  endfunction

endpackage

// File: rtl/omega_cell.sv
// 2x2 self-setting cell. A lane word is {valid, src, dst, data}.
module omega_cell #(
  parameter int LG  = 3,
  parameter int W   = 16,
  parameter int BIT = 2
) (
  input  logic [2*LG+W:0] up_i,
  input  logic [2*LG+W:0] lo_i,
  output logic [2*LG+W:0] up_o,
  output logic [2*LG+W:0] lo_o,
  output logic            lose_o,
  output logic [LG-1:0]   lose_src_o
);
  localparam int V_POS = 2*LG + W;
  localparam int S_LO  = LG + W;
  localparam int D_LO  = W;

  logic up_v, lo_v, up_cross, lo_cross, up_port, lo_port, clash;

  always_comb begin
    up_v     = up_i[V_POS];
    lo_v     = lo_i[V_POS];
    // Crossover when the examined source and destination bits differ.
    up_cross = up_i[S_LO+BIT] ^ up_i[D_LO+BIT];
    lo_cross = lo_i[S_LO+BIT] ^ lo_i[D_LO+BIT];
    up_port  = up_cross;
    lo_port  = ~lo_cross;
    clash    = up_v & lo_v & (up_port == lo_port);

    up_o = '0;
    lo_o = '0;
    if (lo_v && !clash) begin
      if (lo_port) lo_o = lo_i;
      else         up_o = lo_i;
    end
    if (up_v) begin
      if (up_port) lo_o = up_i;
      else         up_o = up_i;
    end
    lose_o     = clash;
    lose_src_o = lo_i[S_LO +: LG];
  end
endmodule

// File: rtl/omega_stage.sv
// One stage: perfect-shuffle wiring followed by P/2 cells.
module omega_stage #(
  parameter int P   = 8,
  parameter int LG  = 3,
  parameter int W   = 16,
  parameter int BIT = 2
) (
  input  logic [P-1:0][2*LG+W:0] lanes_i,
  output logic [P-1:0][2*LG+W:0] lanes_o,
  output logic [P-1:0]           drop_o
);
  localparam int HALF = P / 2;

  logic [P-1:0][2*LG+W:0] shuf;
  logic [HALF-1:0]          lose;
  logic [HALF-1:0][LG-1:0]  lose_src;

  for (genvar i = 0; i < P; i++) begin : g_wire
    localparam int J = omega_pkg::shuffle_idx(i, LG);
    assign shuf[J] = lanes_i[i];
  end

  for (genvar m = 0; m < HALF; m++) begin : g_cell
    omega_cell #(.LG(LG), .W(W), .BIT(BIT)) u_cell (
      .up_i      (shuf[2*m]),
      .lo_i      (shuf[2*m+1]),
      .up_o      (lanes_o[2*m]),
      .lo_o      (lanes_o[2*m+1]),
      .lose_o    (lose[m]),
      .lose_src_o(lose_src[m])
    );
  end

  always_comb begin
    drop_o = '0;
    for (int m = 0; m < HALF; m++) begin
      if (lose[m]) drop_o[lose_src[m]] = 1'b1;
    end
  end
endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter  int P  = 8,
  parameter  int W  = 16,
  localparam int LG = $clog2(P)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [P-1:0]          src_valid,
  input  logic [P-1:0][LG-1:0]  src_dest,
  input  logic [P-1:0][W-1:0]   src_data,
  output logic [P-1:0]          dst_valid,
  output logic [P-1:0][W-1:0]   dst_data,
  output logic [P-1:0][LG-1:0]  dst_src,
  output logic [P-1:0]          src_blocked
);
  localparam int PKW   = 2*LG + W + 1;
  localparam int V_POS = PKW - 1;
  localparam int S_LO  = LG + W;

  logic [LG:0][P-1:0][PKW-1:0] lanes;
  logic [LG-1:0][P-1:0]        drops;
  logic [P-1:0]                drop_any;

  for (genvar i = 0; i < P; i++) begin : g_tag
    assign lanes[0][i] = {src_valid[i], LG'(i), src_dest[i], src_data[i]};
  end

  for (genvar k = 0; k < LG; k++) begin : g_stage
    omega_stage #(.P(P), .LG(LG), .W(W), .BIT(LG-1-k)) u_stage (
      .lanes_i(lanes[k]),
      .lanes_o(lanes[k+1]),
      .drop_o (drops[k])
    );
  end

  always_comb begin
    drop_any = '0;
    for (int k = 0; k < LG; k++) drop_any |= drops[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_valid   <= '0;
      dst_data    <= '0;
      dst_src     <= '0;
      src_blocked <= '0;
    end else begin
      for (int j = 0; j < P; j++) begin
        dst_valid[j] <= lanes[LG][j][V_POS];
        dst_data[j]  <= lanes[LG][j][W-1:0];
        dst_src[j]   <= lanes[LG][j][S_LO +: LG];
      end
      src_blocked <= drop_any;
    end
  end
endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter  int P  = 8,
  parameter  int W  = 16,
  localparam int LG = $clog2(P)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [P-1:0]          src_valid,
  input logic [P-1:0][LG-1:0]  src_dest,
  input logic [P-1:0][W-1:0]   src_data,
  input logic [P-1:0]          dst_valid,
  input logic [P-1:0][W-1:0]   dst_data,
  input logic [P-1:0][LG-1:0]  dst_src,
  input logic [P-1:0]          src_blocked
);
  logic                 armed;
  logic [P-1:0]         prev_valid;
  logic [P-1:0][LG-1:0] prev_dest;
  logic [P-1:0][W-1:0]  prev_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      prev_valid <= '0;
      prev_dest  <= '0;
      prev_data  <= '0;
    end else begin
      armed      <= 1'b1;
      prev_valid <= src_valid;
      prev_dest  <= src_dest;
      prev_data  <= src_data;
    end
  end

  for (genvar j = 0; j < P; j++) begin : g_out
    // R2
    route_dest_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      dst_valid[j] |-> (prev_valid[dst_src[j]] && prev_dest[dst_src[j]] == LG'(j)));
    // R2
    route_data_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      dst_valid[j] |-> (prev_data[dst_src[j]] == dst_data[j]));
    // R6
    blocked_src_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      src_blocked[j] |-> prev_valid[j]);
  end

  // R8
  conserve_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($countones(dst_valid) + $countones(src_blocked)) == $countones(prev_valid));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (dst_valid == '0 && src_blocked == '0));
endmodule

bind omega_net omega_net_chk #(.P(P), .W(W)) u_omega_net_chk (
  .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_dest(src_dest),
  .src_data(src_data), .dst_valid(dst_valid), .dst_data(dst_data),
  .dst_src(dst_src), .src_blocked(src_blocked)
);

// File: tb/test_omega_net.sv
`timescale 1ns/1ps
module test_omega_net;
  localparam int P  = 8;
  localparam int W  = 16;
  localparam int LG = 3;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [P-1:0]         src_valid = '0;
  logic [P-1:0][LG-1:0] src_dest = '0;
  logic [P-1:0][W-1:0]  src_data = '0;
  logic [P-1:0]         dst_valid;
  logic [P-1:0][W-1:0]  dst_data;
  logic [P-1:0][LG-1:0] dst_src;
  logic [P-1:0]         src_blocked;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  omega_net #(.P(P), .W(W)) i_omega_net (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_dest(src_dest),
    .src_data(src_data), .dst_valid(dst_valid), .dst_data(dst_data),
    .dst_src(dst_src), .src_blocked(src_blocked)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pay(input int s, input int d);
    return W'(16'hA500 | (s << 4) | d);
  endfunction

  // Drive on a falling edge, sample 1 ns after the next rising edge.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    src_valid = '0;
    src_dest  = '1;
    src_data  = '1;
  endtask

  task automatic t_reset();
    #1;
    chk(dst_valid == '0 && src_blocked == '0, "R1 in reset", {dst_valid, src_blocked}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle();
    step();
    chk(dst_valid == '0 && src_blocked == '0, "R1 after release", {dst_valid, src_blocked}, 0);
  endtask

  task automatic t_example();
    idle();
    src_valid[1] = 1'b1; src_dest[1] = 3'd4; src_data[1] = pay(1, 4);
    step();
    chk(dst_valid == 8'h10, "R3 1->4 valid", dst_valid, 8'h10);
    chk(dst_src[4] == 3'd1 && dst_data[4] == pay(1, 4), "R3 1->4 tag", {dst_src[4], dst_data[4]}, {3'd1, pay(1, 4)});
  endtask

  task automatic t_perm(input bit comp, input string req);
    logic ok;
    idle();
    for (int s = 0; s < P; s++) begin
      src_valid[s] = 1'b1;
      src_dest[s]  = comp ? LG'(s ^ (P-1)) : LG'(s);
      src_data[s]  = pay(s, comp ? s ^ (P-1) : s);
    end
    step();
    chk(dst_valid == '1 && src_blocked == '0, req, {dst_valid, src_blocked}, 16'hFF00);
    ok = 1'b1;
    for (int d = 0; d < P; d++) begin
      int s = comp ? d ^ (P-1) : d;
      if (dst_src[d] != LG'(s) || dst_data[d] != pay(s, d)) ok = 1'b0;
    end
    chk(ok, {req, " tags"}, 0, 1);
  endtask

  task automatic t_sweep();
    for (int s = 0; s < P; s++) begin
      for (int d = 0; d < P; d++) begin
        idle();
        src_valid[s] = 1'b1; src_dest[s] = LG'(d); src_data[s] = pay(s, d);
        step();
        chk(dst_valid == P'(1 << d) && src_blocked == '0 && dst_src[d] == LG'(s) && dst_data[d] == pay(s, d),
            $sformatf("R2 sweep %0d->%0d", s, d), {dst_valid, dst_src[d], dst_data[d]},
            {P'(1 << d), LG'(s), pay(s, d)});
      end
    end
  endtask

  // Sources 0->0 and 4->1 meet in cell 0 of stage 1 and want the same port;
  // 7->7 travels alongside untouched.
  task automatic t_clash_first();
    idle();
    src_valid[0] = 1'b1; src_dest[0] = 3'd0; src_data[0] = pay(0, 0);
    src_valid[4] = 1'b1; src_dest[4] = 3'd1; src_data[4] = pay(4, 1);
    src_valid[7] = 1'b1; src_dest[7] = 3'd7; src_data[7] = pay(7, 7);
    step();
    chk(dst_valid == 8'h81, "R5 winner delivered", dst_valid, 8'h81);
    chk(dst_src[0] == 3'd0 && dst_data[0] == pay(0, 0), "R5 upper line wins", dst_src[0], 0);
    chk(src_blocked == 8'h10, "R6 loser flagged", src_blocked, 8'h10);
    idle();
    step();
    chk(src_blocked == '0 && dst_valid == '0, "R6 flag lasts one cycle", {dst_valid, src_blocked}, 0);
  endtask

  // Sources 0->4 and 2->5 leave different stage-1 cells and meet in stage 2.
  task automatic t_clash_later();
    idle();
    src_valid[0] = 1'b1; src_dest[0] = 3'd4; src_data[0] = pay(0, 4);
    src_valid[2] = 1'b1; src_dest[2] = 3'd5; src_data[2] = pay(2, 5);
    step();
    chk(dst_valid == 8'h10 && dst_src[4] == 3'd0, "R9 later-stage winner", {dst_valid, dst_src[4]}, {8'h10, 3'd0});
    chk(src_blocked == 8'h04, "R9 later-stage loser flagged", src_blocked, 8'h04);
    chk($countones(dst_valid) + $countones(src_blocked) == 2, "R8 each packet accounted",
        $countones(dst_valid) + $countones(src_blocked), 2);
  endtask

  task automatic t_ignored();
    idle();
    src_dest = {P{3'd2}};
    src_data = {P{16'hDEAD}};
    step();
    chk(dst_valid == '0 && src_blocked == '0, "R7 invalid inputs ignored", {dst_valid, src_blocked}, 0);
  endtask

  task automatic t_back_to_back();
    idle();
    src_valid[3] = 1'b1; src_dest[3] = 3'd6; src_data[3] = pay(3, 6);
    step();
    chk(dst_valid == 8'h40 && dst_src[6] == 3'd3, "R10 first packet", {dst_valid, dst_src[6]}, {8'h40, 3'd3});
    idle();
    src_valid[5] = 1'b1; src_dest[5] = 3'd2; src_data[5] = pay(5, 2);
    step();
    chk(dst_valid == 8'h04 && dst_src[2] == 3'd5 && dst_data[2] == pay(5, 2), "R10 second packet",
        {dst_valid, dst_src[2]}, {8'h04, 3'd5});
    idle();
    step();
    chk(dst_valid == '0, "R10 idle clears outputs", dst_valid, 0);
  endtask

  initial begin
    t_reset();
    t_example();
    t_perm(1'b0, "R4 identity");
    t_perm(1'b1, "R4 complement");
    t_sweep();
    t_clash_first();
    t_clash_later();
    t_ignored();
    t_back_to_back();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule